// File: doc/BRIEF.md
# Interrupt Redirection Register File

This block holds the configuration of a 24-input interrupt router behind a two-location software window. One location is an 8-bit select register. The other is a 32-bit data port that reaches whichever internal register the select value names. The internal registers are an 8-bit unit identifier, a read-only version word, and one 64-bit redirection entry per interrupt input. Each entry is reached as two 32-bit halves at two neighbouring select values.

The whole table is driven out in parallel for the dispatch logic. After every accepted entry write, a one-cycle strobe tells that logic to evaluate its pending inputs again. Only the low byte of the bus address is decoded. Decode of the higher address bits belongs to the enclosing fabric.

Top module: `irq_redir_regs`

## Requirements
- R1: After reset the select register reads 0x00, the identifier reads 0, and every entry holds 0x0000_0000_0001_0000 (only bit 16, the mask bit, set). `table_o` shows these values, with entry n at bits n*64+63 : n*64.
- R2: Address low byte 0x00 is the select register. A write loads `bus_wdata[7:0]`. A read returns the stored 8 bits in bits 7:0 and zero above them.
- R3: With select 0x00, the data port at low byte 0x10 reads the identifier in bits 31:24 and zero elsewhere. A write there loads the identifier from `bus_wdata[31:24]`.
- R4: With select 0x01, the data port reads 0x0017_0011: version 0x11 in bits 7:0 and the highest entry number, 23, in bits 23:16. Writes there are discarded.
- R5: Select values 0x02 through 0x0F read as zero through the data port. Writes at these values change nothing.
- R6: For a select value s of 0x10 or more, the entry index is (s − 0x10) >> 1. An even s reaches bits 31:0 of that entry and an odd s reaches bits 63:32, for both reads and writes.
- R7: A write to one half of an entry leaves the other half of that entry, and all other entries, unchanged.
- R8: If the entry index is 24 or more, reads return zero, writes change nothing, and no update strobe is raised.
- R9: Reads at any address low byte other than 0x00 and 0x10 return zero, and writes there change nothing. Address bits above bit 7 are ignored.
- R10: `upd_o` is high for exactly the one cycle after each accepted entry write, and is low at all other times. `table_o` changes only in a cycle where `upd_o` is high.
- R11: `bus_rdata` is registered. It shows the value selected by the address and state present at the clock edge where `bus_re` is high, and holds that value while `bus_re` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 are decoded |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data |
| table_o | output | NUM_ENTRIES*64 | All redirection entries, entry n at bits n*64+63 : n*64 |
| upd_o | output | 1 | One-cycle strobe after each accepted entry write |

## Verification
Most of the stimulus is random. Select writes are biased so that they land on the identifier, the version word, the reserved codes, the valid entry halves, and the indices just past the table. Data-port writes carry random words, so a half swapped between even and odd select values, or a write that spills into the neighbouring half, shows up in both the read-back and `table_o`. Directed cases cover the boundaries that random traffic rarely reaches: the last valid index against the first invalid one, select 0xFF, offsets next to 0x00 and 0x10, and addresses with the upper bits set. Each of these tells a full 8-bit compare apart from a truncated one.

// File: rtl/irq_redir_regs.sv
module irq_redir_regs #(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 12,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_we,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_re,
  output logic [31:0]               bus_rdata,
  output logic [NUM_ENTRIES*64-1:0] table_o,
  output logic                      upd_o
);
  localparam int IW = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
  localparam logic [6:0]  NUM_L   = 7'(NUM_ENTRIES);
  localparam logic [7:0]  LAST_L  = 8'(NUM_ENTRIES - 1);
  localparam logic [63:0] ENT_RST = 64'h1 << 16;
  localparam logic [7:0]  OFS_SEL = 8'h00;
  localparam logic [7:0]  OFS_WIN = 8'h10;
  localparam logic [7:0]  TBL_LO  = 8'h10;

  logic [7:0]  sel_q, id_q;
  logic [63:0] ent_q [NUM_ENTRIES];
  logic [31:0] win_val;

  wire [7:0]    off     = bus_addr[7:0];
  wire          sel_hit = off == OFS_SEL;
  wire          win_hit = off == OFS_WIN;
  wire [7:0]    rel     = sel_q - TBL_LO;
  wire [6:0]    idx     = rel[7:1];
  wire [IW-1:0] idx_s   = idx[IW-1:0];
  wire          idx_ok  = (sel_q >= TBL_LO) && (idx < NUM_L);
  wire          ent_wr  = bus_we && win_hit && idx_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      id_q  <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= ent_wr;
      if (bus_we && sel_hit) sel_q <= bus_wdata[7:0];
      if (bus_we && win_hit && sel_q == 8'h00) id_q <= bus_wdata[31:24];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) ent_q[i] <= ENT_RST;
    end else if (ent_wr) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (idx == 7'(i)) begin
          if (sel_q[0]) ent_q[i][63:32] <= bus_wdata;
          else          ent_q[i][31:0]  <= bus_wdata;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_out
    assign table_o[g*64 +: 64] = ent_q[g];
  end

  always_comb begin
    case (sel_q)
      8'h00:   win_val = {id_q, 24'h0};
      8'h01:   win_val = {8'h00, LAST_L, 8'h00, VERSION};
      default: win_val = !idx_ok ? 32'h0 :
                         (sel_q[0] ? ent_q[idx_s][63:32] : ent_q[idx_s][31:0]);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_re) bus_rdata <= sel_hit ? {24'h0, sel_q} : (win_hit ? win_val : 32'h0);
  end
endmodule

// File: rtl/irq_redir_regs_chk.sv
module irq_redir_regs_chk #(
  parameter int NUM_ENTRIES = 24,
  parameter int ADDR_W      = 12
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic                      bus_re,
  input logic [31:0]               bus_rdata,
  input logic [NUM_ENTRIES*64-1:0] table_o,
  input logic                      upd_o,
  input logic [7:0]                sel_q
);
  a_r2_sel_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr[7:0] == 8'h00) |=> $stable(sel_q));

  a_r10_table_moves_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(table_o));

  a_r10_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> $past(bus_we && bus_addr[7:0] == 8'h10 && sel_q >= 8'h10));

  a_r8_no_strobe_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && sel_q >= 8'h10 && ((sel_q - 8'h10) >> 1) >= 8'(NUM_ENTRIES)) |=> !upd_o);

  a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

bind irq_redir_regs irq_redir_regs_chk #(.NUM_ENTRIES(NUM_ENTRIES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .table_o(table_o), .upd_o(upd_o), .sel_q(sel_q));

// File: tb/irq_redir_regs_bench.sv
`timescale 1ns/1ps
module irq_redir_regs_bench;
  localparam int N  = 24;
  localparam int AW = 12;

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 0, bus_re = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N*64-1:0] table_o;
  logic upd_o;

  int tests = 0, fails = 0;
  logic [7:0]  m_sel, m_id;
  logic [63:0] m_tab [N];

  irq_redir_regs #(.NUM_ENTRIES(N), .ADDR_W(AW)) u_irq_redir_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_re(bus_re), .bus_rdata(bus_rdata), .table_o(table_o), .upd_o(upd_o));

  always #2.5 clk = ~clk;

  function automatic bit ent_ok(input logic [7:0] s);
    return s >= 8'h10 && ((s - 8'h10) >> 1) < N;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] off);
    int ix;
    if (off == 8'h00) return {24'h0, m_sel};
    if (off != 8'h10) return 32'h0;
    if (m_sel == 8'h00) return {m_id, 24'h0};
    if (m_sel == 8'h01) return {8'h00, 8'(N - 1), 8'h00, 8'h11};
    if (!ent_ok(m_sel)) return 32'h0;
    ix = (m_sel - 8'h10) >> 1;
    return m_sel[0] ? m_tab[ix][63:32] : m_tab[ix][31:0];
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_table(input string req);
    for (int i = 0; i < N; i++) check(req, table_o[i*64 +: 64], m_tab[i]);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, input string req);
    bit hit;
    int ix;
    hit = 0;
    bus_addr = a; bus_wdata = d; bus_we = 1;
    if (a[7:0] == 8'h00) m_sel = d[7:0];
    else if (a[7:0] == 8'h10) begin
      if (m_sel == 8'h00) m_id = d[31:24];
      else if (ent_ok(m_sel)) begin
        hit = 1;
        ix = (m_sel - 8'h10) >> 1;
        if (m_sel[0]) m_tab[ix][63:32] = d; else m_tab[ix][31:0] = d;
      end
    end
    @(negedge clk);
    bus_we = 0;
    check({req, " strobe R10"}, {63'h0, upd_o}, {63'h0, hit});
  endtask

  task automatic rd(input logic [AW-1:0] a, input string req);
    logic [31:0] e;
    e = exp_rd(a[7:0]);
    bus_addr = a; bus_re = 1;
    @(negedge clk);
    bus_re = 0;
    check(req, {32'h0, bus_rdata}, {32'h0, e});
    check("R10 idle strobe", {63'h0, upd_o}, 64'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d48));
    m_sel = 0; m_id = 0;
    for (int i = 0; i < N; i++) m_tab[i] = 64'h1_0000;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check_table("R1 reset table");
    rd(12'h000, "R1 reset select");
    wr(12'h000, 32'h0, "R1");
    rd(12'h010, "R1 reset id");
    wr(12'h000, 32'h10, "R1");
    rd(12'h010, "R1 reset entry0 low");

    // R2 select, R3 id
    wr(12'h000, 32'hFFFF_FFA5, "R2");
    rd(12'h000, "R2 select readback");
    wr(12'h000, 32'h0, "R3");
    wr(12'h010, 32'hC3FF_FFFF, "R3");
    rd(12'h010, "R3 id readback");

    // R4 version, R5 reserved
    wr(12'h000, 32'h1, "R4");
    wr(12'h010, 32'hFFFF_FFFF, "R4");
    rd(12'h010, "R4 version");
    for (int s = 2; s < 16; s++) begin
      wr(12'h000, 32'(s), "R5");
      wr(12'h010, 32'hDEAD_BEEF, "R5");
      rd(12'h010, "R5 reserved reads zero");
    end
    wr(12'h000, 32'h0, "R5");
    rd(12'h010, "R5 id unchanged");
    check_table("R5 table unchanged");

    // R6/R7 halves of last valid entry
    wr(12'h000, 32'h3F, "R6");
    wr(12'h010, 32'h1234_5678, "R6");
    wr(12'h000, 32'h3E, "R7");
    wr(12'h010, 32'h9ABC_DEF0, "R7");
    rd(12'h010, "R6 low half");
    wr(12'h000, 32'h3F, "R7");
    rd(12'h010, "R7 high half kept");
    check_table("R7 table");

    // R8 past the end
    foreach (m_tab[i]) ;
    for (int s = 8'h40; s <= 8'h42; s++) begin
      wr(12'h000, 32'(s), "R8");
      wr(12'h010, 32'hFFFF_FFFF, "R8");
      rd(12'h010, "R8 out of range zero");
    end
    wr(12'h000, 32'hFF, "R8");
    wr(12'h010, 32'hFFFF_FFFF, "R8");
    rd(12'h010, "R8 select FF zero");
    check_table("R8 table unchanged");

    // R9 other offsets, upper bits ignored
    rd(12'h004, "R9 offset 04");
    rd(12'h014, "R9 offset 14");
    wr(12'h001, 32'h0000_0033, "R9");
    wr(12'h011, 32'h5555_5555, "R9");
    rd(12'hA00, "R9 upper bits select");
    wr(12'hB00, 32'h12, "R9");
    wr(12'h710, 32'hCAFE_F00D, "R9");
    rd(12'hF10, "R9 upper bits window");
    check_table("R9 table");

    // R11 hold while re low
    repeat (3) @(negedge clk);
    check("R11 hold", {32'h0, bus_rdata}, {32'h0, exp_rd(8'h10)});

    // random traffic
    for (int k = 0; k < 600; k++) begin
      int op;
      op = $urandom % 5;
      case (op)
        0: wr({4'($urandom), 8'h00}, {24'($urandom), 8'($urandom % 8'h48)}, "R6 rand select");
        1: wr({4'($urandom), 8'h10}, $urandom, "R7 rand write");
        2: rd({4'($urandom), 8'h10}, "R11 rand window read");
        3: rd({4'($urandom), 8'h00}, "R2 rand select read");
        default: rd({4'($urandom), 8'($urandom)}, "R9 rand offset read");
      endcase
      if (k % 50 == 0) check_table("R6 rand table");
    end
    check_table("R7 final table");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule